// File: doc/BRIEF.md
# Ranged Byte Compare Execution Unit

This unit executes an integer instruction that asks whether a single byte lies inside one or two inclusive, unsigned byte ranges. The instruction word, the first operand (which supplies the byte) and the second operand (which packs the range bounds) arrive together with an input valid. The unit decodes the word, rejects it if it is not the expected instruction, and compares the byte against the ranges. It then reports a write of one 4-bit field of a 32-bit condition register.

The result is registered once. One cycle after the input, the unit presents the output valid, an illegal-instruction flag, the index of the target field and the new field value. A condition-field write takes place when output valid is high and illegal is low. A failed range test still writes the field, with all of its bits cleared. The surrounding pipeline owns the condition register. The bench keeps a small model of that register to show the effect of each write.

Reset `rst_n` is active low. It asserts asynchronously and must be released in step with `clk`.

Top module: `rngbyte_exec`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low otherwise. Reset clears `out_valid`.
- R2: The instruction is accepted only when `in_insn[31:26]` equals 31 and `in_insn[10:1]` equals 192 (sub-field `in_insn[10:6]` = 6, `in_insn[5:1]` = 0). Any other word raises `out_illegal` and drives `out_fld_val` to 0, and no field write occurs.
- R3: A word whose reserved bit 22 or reserved bit 0 is set raises `out_illegal` and drives `out_fld_val` to 0, even when the opcode fields match.
- R4: `out_fld_idx` equals `in_insn[25:23]`. Field index k maps to condition-register bits [31-4k : 28-4k], so field 0 is bits 31:28.
- R5: Only `in_opa[7:0]` is compared. Bits 63:8 of the first operand have no effect on the result.
- R6: The first range has its lower bound in `in_opb[7:0]` and its upper bound in `in_opb[15:8]`. The comparison is unsigned and inclusive at both ends. Bits 63:32 of the second operand have no effect.
- R7: When `in_insn[21]` is 1, a second range with lower bound `in_opb[23:16]` and upper bound `in_opb[31:24]` is also tested, and the result is a match if either range matches. When `in_insn[21]` is 0, bits 31:16 of the second operand have no effect.
- R8: The field bit order from most to least significant is LT, GT, EQ, SO. A legal instruction that matches writes 4'b0100. A legal instruction with no match writes 4'b0000.
- R9: A range whose lower bound is greater than its upper bound never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Instruction and operands are present |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 64 | First operand; its low byte is tested |
| in_opb | input | 64 | Second operand; low 32 bits hold the range bounds |
| out_valid | output | 1 | Result present, one cycle after `in_valid` |
| out_illegal | output | 1 | Instruction word was rejected |
| out_fld_idx | output | 3 | Condition field to write |
| out_fld_val | output | 4 | Value for that field (LT, GT, EQ, SO) |

## Verification
The in-RTL assertions check the following on every cycle:
- the one-cycle valid timing;
- that reserved bits or a wrong primary opcode lead to the illegal flag;
- that a rejected word carries a zero field value;
- that only the GT bit can ever be set;
- that the field index follows the word;
- that an inverted range never reports a hit;
- that, in single-range mode, a byte outside the first range yields zero.

Only the bench's scenarios can show the rest:
- the inclusive edges of each range;
- that high operand bits and the unused second range are really ignored;
- the OR of the two ranges;
- that a no-match write clears a previously set field in the condition-register model.

// File: rtl/rngbyte_pkg.sv
package rngbyte_pkg;

  // Instruction encoding constants (bit 0 is the least significant bit)
  localparam logic [5:0]  PRIM_OP     = 6'd31;
  localparam logic [9:0]  EXT_OP      = 10'd192;
  localparam logic [31:0] RSV_MASK    = 32'h0040_0001;
  localparam int unsigned DUAL_BIT    = 21;
  localparam int unsigned FLD_HI      = 25;
  localparam int unsigned FLD_LO      = 23;

  // Condition field layout: LT, GT, EQ, SO from msb to lsb
  localparam int unsigned FLD_W       = 4;
  localparam int unsigned FLD_IDX_W   = 3;
  localparam logic [FLD_W-1:0] FLD_GT = 4'b0100;

  typedef struct packed {
    logic                 legal;
    logic                 dual;
    logic [FLD_IDX_W-1:0] fld;
  } dec_t;

endpackage

// File: rtl/rngbyte_decode.sv
module rngbyte_decode
  import rngbyte_pkg::*;
#(
  parameter int unsigned INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);

  logic prim_ok;
  logic ext_ok;
  logic rsv_ok;
  logic unused_regs;

  always_comb begin
    prim_ok   = (insn[31:26] == PRIM_OP);
    ext_ok    = (insn[10:1] == EXT_OP);
    rsv_ok    = ((insn & RSV_MASK) == '0);
    dec.legal = prim_ok & ext_ok & rsv_ok;
    dec.dual  = insn[DUAL_BIT];
    dec.fld   = insn[FLD_HI:FLD_LO];
  end

  // register specifier fields are not used: operands arrive by value
  assign unused_regs = ^insn[20:11];

endmodule

// File: rtl/rngbyte_window.sv
module rngbyte_window #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              en,
  input  logic [BYTE_W-1:0] val,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] hi,
  output logic              hit
);

  logic below;
  logic above;

  always_comb begin
    below = (val < lo);
    above = (val > hi);
    hit   = en & ~below & ~above;
  end

endmodule

// File: rtl/rngbyte_out_stage.sv
module rngbyte_out_stage #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned VAL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  logic             d_illegal,
  input  logic [IDX_W-1:0] d_idx,
  input  logic [VAL_W-1:0] d_val,
  output logic             q_valid,
  output logic             q_illegal,
  output logic [IDX_W-1:0] q_idx,
  output logic [VAL_W-1:0] q_val
);

  logic             valid_nx;
  logic             load_en;
  logic             illegal_nx;
  logic [IDX_W-1:0] idx_nx;
  logic [VAL_W-1:0] val_nx;

  always_comb begin
    load_en    = d_valid;
    valid_nx   = d_valid;
    illegal_nx = load_en ? d_illegal : q_illegal;
    idx_nx     = load_en ? d_idx     : q_idx;
    val_nx     = load_en ? d_val     : q_val;
  end

  // control flop with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= valid_nx;
  end

  // data flops without reset, loaded under enable
  always_ff @(posedge clk) begin
    q_illegal <= illegal_nx;
    q_idx     <= idx_nx;
    q_val     <= val_nx;
  end

endmodule

// File: rtl/rngbyte_exec.sv
module rngbyte_exec
  import rngbyte_pkg::*;
#(
  parameter int unsigned INSN_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned NUM_RANGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSN_W-1:0]    in_insn,
  input  logic [DATA_W-1:0]    in_opa,
  input  logic [DATA_W-1:0]    in_opb,
  output logic                 out_valid,
  output logic                 out_illegal,
  output logic [FLD_IDX_W-1:0] out_fld_idx,
  output logic [FLD_W-1:0]     out_fld_val
);

  localparam int unsigned PAIR_W = 2 * BYTE_W;
  localparam int unsigned PACK_W = NUM_RANGES * PAIR_W;

  dec_t                  dec;
  logic [BYTE_W-1:0]     probe;
  logic [NUM_RANGES-1:0] rng_hit;
  logic [NUM_RANGES-1:0] rng_en;
  logic [BYTE_W-1:0]     rng_lo [NUM_RANGES];
  logic [BYTE_W-1:0]     rng_hi [NUM_RANGES];
  logic                  any_hit;
  logic                  nx_illegal;
  logic [FLD_W-1:0]      nx_val;
  logic                  unused_hi;

  rngbyte_decode #(.INSN_W(INSN_W)) u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  assign probe     = in_opa[BYTE_W-1:0];
  assign unused_hi = ^{in_opa[DATA_W-1:BYTE_W], in_opb[DATA_W-1:PACK_W]};

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
    assign rng_lo[r] = in_opb[r*PAIR_W +: BYTE_W];
    assign rng_hi[r] = in_opb[r*PAIR_W + BYTE_W +: BYTE_W];
    if (r == 0) begin : g_first
      assign rng_en[r] = 1'b1;
    end else begin : g_extra
      assign rng_en[r] = dec.dual;
    end

    rngbyte_window #(.BYTE_W(BYTE_W)) u_win (
      .en  (rng_en[r]),
      .val (probe),
      .lo  (rng_lo[r]),
      .hi  (rng_hi[r]),
      .hit (rng_hit[r])
    );

    // R9: an inverted range never reports a hit
    p_inverted_nohit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rng_lo[r] > rng_hi[r]) |-> !rng_hit[r]);
  end

  always_comb begin
    any_hit    = |rng_hit;
    nx_illegal = ~dec.legal;
    nx_val     = (dec.legal && any_hit) ? FLD_GT : '0;
  end

  rngbyte_out_stage #(.IDX_W(FLD_IDX_W), .VAL_W(FLD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_valid   (in_valid),
    .d_illegal (nx_illegal),
    .d_idx     (dec.fld),
    .d_val     (nx_val),
    .q_valid   (out_valid),
    .q_illegal (out_illegal),
    .q_idx     (out_fld_idx),
    .q_val     (out_fld_val)
  );

  // R1: output valid trails input valid by one cycle
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2: wrong primary opcode is rejected
  p_bad_prim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_insn[31:26] != PRIM_OP) |=> out_illegal);

  // R2: a rejected word never carries a field value
  p_illegal_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_fld_val == '0));

  // R3: reserved bits force rejection
  p_rsv_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_insn & RSV_MASK) != '0) |=> out_illegal);

  // R4: field index follows the instruction word
  p_fld_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_fld_idx == $past(in_insn[FLD_HI:FLD_LO])));

  // R8: only the GT bit may be set
  p_only_gt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_fld_val & ~FLD_GT) == '0));

  // R7: single-range mode with the byte outside range 0 yields no match
  p_single_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_insn[DUAL_BIT] &&
     (in_opa[BYTE_W-1:0] < in_opb[BYTE_W-1:0] ||
      in_opa[BYTE_W-1:0] > in_opb[PAIR_W-1:BYTE_W])) |=> (out_fld_val == '0));

endmodule

// File: tb/rngbyte_exec_tb_top.sv
module rngbyte_exec_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_insn;
  logic [63:0] in_opa;
  logic [63:0] in_opb;
  logic        out_valid;
  logic        out_illegal;
  logic [2:0]  out_fld_idx;
  logic [3:0]  out_fld_val;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  logic [31:0] cr_act;
  logic [31:0] cr_exp;

  rngbyte_exec dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_insn     (in_insn),
    .in_opa      (in_opa),
    .in_opb      (in_opb),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_fld_idx (out_fld_idx),
    .out_fld_val (out_fld_val)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  function automatic logic [31:0] mk(input logic [5:0] prim, input logic [2:0] bf,
                                     input logic dual, input logic [9:0] ext,
                                     input logic r22, input logic r0);
    return {prim, bf, r22, dual, 5'd3, 5'd4, ext, r0};
  endfunction

  function automatic logic ref_legal(input logic [31:0] w);
    return (w[31:26] == 6'd31) && (w[10:1] == 10'd192) && !w[22] && !w[0];
  endfunction

  function automatic logic ref_hit(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
    logic [7:0] v;
    logic h0, h1;
    v  = a[7:0];
    h0 = (v >= b[7:0]) && (v <= b[15:8]);
    h1 = w[21] && (v >= b[23:16]) && (v <= b[31:24]);
    return h0 || h1;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // drive one op, check the registered result one cycle later
  task automatic do_op(input string req, input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
    logic       lg;
    logic [3:0] ev;
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_opa = a; in_opb = b;
    @(negedge clk);
    in_valid = 1'b0;
    lg = ref_legal(w);
    ev = (lg && ref_hit(w, a, b)) ? 4'b0100 : 4'b0000;
    if (lg) cr_exp[31 - 4*w[25:23] -: 4] = ev;
    if (out_valid && !out_illegal) cr_act[31 - 4*out_fld_idx -: 4] = out_fld_val;
    check("R1", "out_valid", {31'd0, out_valid}, 32'd1);
    check(lg ? req : "R2/R3", "out_illegal", {31'd0, out_illegal}, {31'd0, !lg});
    check(req, "out_fld_val", {28'd0, out_fld_val}, {28'd0, ev});
    if (lg) check("R4", "out_fld_idx", {29'd0, out_fld_idx}, {29'd0, w[25:23]});
    check("R4", "cr_model", cr_act, cr_exp);
  endtask

  localparam logic [5:0] P = 6'd31;
  localparam logic [9:0] E = 10'd192;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_opa = '0; in_opb = '0;
    cr_act = 32'hFFFF_FFFF; cr_exp = 32'hFFFF_FFFF;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle out_valid", {31'd0, out_valid}, 32'd0);

    // R6 inclusive edges, single range 0x41..0x5A
    do_op("R6", mk(P, 3'd0, 1'b0, E, 1'b0, 1'b0), 64'h41, 64'h5A41);
    do_op("R6", mk(P, 3'd1, 1'b0, E, 1'b0, 1'b0), 64'h5A, 64'h5A41);
    do_op("R6", mk(P, 3'd2, 1'b0, E, 1'b0, 1'b0), 64'h40, 64'h5A41);
    do_op("R6", mk(P, 3'd3, 1'b0, E, 1'b0, 1'b0), 64'h5B, 64'h5A41);
    // R6 high operand bits ignored
    do_op("R6", mk(P, 3'd4, 1'b0, E, 1'b0, 1'b0), 64'h50, 64'hFFFF_FFFF_0000_5A41);
    // R5 high bits of first operand ignored
    do_op("R5", mk(P, 3'd5, 1'b0, E, 1'b0, 1'b0), 64'hFFFF_FFFF_FFFF_FF45, 64'h5A41);
    do_op("R5", mk(P, 3'd6, 1'b0, E, 1'b0, 1'b0), 64'h4545_4545_4545_4500, 64'h5A41);
    // R7 second range used only when the mode bit is set
    do_op("R7", mk(P, 3'd7, 1'b1, E, 1'b0, 1'b0), 64'h65, 64'h7A61_5A41);
    do_op("R7", mk(P, 3'd7, 1'b0, E, 1'b0, 1'b0), 64'h65, 64'h7A61_5A41);
    do_op("R7", mk(P, 3'd0, 1'b1, E, 1'b0, 1'b0), 64'h7A, 64'h7A61_5A41);
    // R9 inverted ranges
    do_op("R9", mk(P, 3'd1, 1'b1, E, 1'b0, 1'b0), 64'h50, 64'h4060_415A);
    do_op("R9", mk(P, 3'd2, 1'b0, E, 1'b0, 1'b0), 64'h41, 64'h0000_415A);
    // R8 match writes GT; then miss clears the same field
    do_op("R8", mk(P, 3'd3, 1'b0, E, 1'b0, 1'b0), 64'h00, 64'h0000);
    do_op("R8", mk(P, 3'd3, 1'b0, E, 1'b0, 1'b0), 64'hFF, 64'h0000);
    // R3 reserved bits
    do_op("R3", mk(P, 3'd4, 1'b0, E, 1'b1, 1'b0), 64'h50, 64'h5A41);
    do_op("R3", mk(P, 3'd4, 1'b0, E, 1'b0, 1'b1), 64'h50, 64'h5A41);
    // R2 wrong opcodes
    do_op("R2", mk(6'd30, 3'd5, 1'b0, E, 1'b0, 1'b0), 64'h50, 64'h5A41);
    do_op("R2", mk(P, 3'd5, 1'b0, 10'd193, 1'b0, 1'b0), 64'h50, 64'h5A41);
    do_op("R2", mk(P, 3'd5, 1'b0, 10'd6, 1'b0, 1'b0), 64'h50, 64'h5A41);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [63:0] a, b;
      logic [7:0]  l0, l1, span0, span1;
      int unsigned pick;
      pick  = $urandom % 10;
      l0    = 8'($urandom); l1 = 8'($urandom);
      span0 = 8'($urandom % 64); span1 = 8'($urandom % 64);
      b = {32'($urandom), 8'(l1 + span1), l1, 8'(l0 + span0), l0};
      a = {56'({$urandom, $urandom}), 8'($urandom)};
      w = mk(P, 3'($urandom), 1'($urandom), E, 1'b0, 1'b0);
      if (pick == 0) w = $urandom;
      else if (pick == 1) w[22] = 1'b1;
      else if (pick == 2) w[0] = 1'b1;
      do_op("R7", w, a, b);
      if ((i % 50) == 0) begin
        @(negedge clk);
        check("R1", "gap out_valid", {31'd0, out_valid}, 32'd0);
      end
    end

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    finish_run();
  end

endmodule